// File: doc/BRIEF.md
# Synchronous Bus Block-Read Slave

This block is the memory side of a clocked parallel bus. It serves plain single-word reads and burst reads. A master starts an access by driving an address and raising the memory-request and read strobes for one cycle. It may also raise a block-select line. When block-select is high, the master places a beat count on the data lines in that same first cycle.

The slave latches the address and the count at the end of the first cycle. It raises its wait line for exactly one cycle. From then on it returns one word per clock from consecutive word addresses until the count is used up. A read-only word array, built from a fixed pattern, supplies the words.

A single-word read therefore takes three bus cycles. A four-beat burst takes six, where four separate reads would take twelve. The master keeps memory-request high for the whole access. It drops memory-request to end the access, or to abandon a burst early.

Top module: `bus_blkrd_slave`

## Requirements
- R1: While rst_ni is low, wait_o, valid_o and data_oe_o are low and data_o is zero.
- R2: A read started with block_i low returns exactly one word, whatever the data lines carry. The cycle after the start cycle is a wait cycle, and the word is on data_o in the cycle after that, so the access spans three cycles.
- R3: A read started with block_i high takes its beat count from data_i[CNT_W-1:0] in the start cycle. It returns that many words on consecutive clocks with no gaps. A 4-beat burst ends in its sixth cycle, counting the start cycle.
- R4: wait_o is high in exactly one cycle per access: the cycle right after the start cycle. It is low at all other times.
- R5: Beat n (counting from 0) carries the word at address (start address + n) modulo 2^ADDR_W.
- R6: A block count of 0 is served as one beat. A block count above MAX_BEATS (8 by default) is served as MAX_BEATS beats.
- R7: valid_o and data_oe_o are high in exactly as many cycles as the transfer has beats. data_o is zero whenever valid_o is low.
- R8: Once memory-request is released, valid_o and wait_o are low from the next cycle on, and a burst in progress stops. No new access starts until memory-request has been low for at least one clock edge.
- R9: Memory-request held high with the read strobe low starts no access: wait_o and valid_o stay low.
- R10: The word at address a is made of DATA_W/16 lanes of 16 bits. Lane k, with lane 0 in the lowest bits, holds (0xB000 + 256*k + a) modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mreq_i | input | 1 | Memory request, held for the whole access |
| rd_i | input | 1 | Read strobe |
| block_i | input | 1 | Block-transfer select, sampled in the start cycle |
| addr_i | input | ADDR_W | Start word address, sampled in the start cycle |
| data_i | input | DATA_W | Data lines from the master; the low CNT_W bits are the beat count |
| data_o | output | DATA_W | Read data driven by the slave |
| data_oe_o | output | 1 | Slave drives the data lines |
| wait_o | output | 1 | Wait line, stretches the access before the first word |
| valid_o | output | 1 | A read word is on data_o |

## Verification
The bench uses the defaults: DATA_W=64, ADDR_W=6 (a 64-word array) and MAX_BEATS=8, which gives a 4-bit count field. With this small array, a burst that starts at address 62 or 63 crosses the wrap point. With the 4-bit field, counts of 0, 8 and 15 reach the single-beat case, the largest legal burst and the clamp. The full 64-bit word makes every one of the four lanes visible, so a wrong address or lane shows as a data mismatch.

// File: rtl/bus_blkrd_pkg.sv
package bus_blkrd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_STREAM,
    ST_HOLD
  } bus_state_e;

  localparam int unsigned LANE_W    = 16;
  localparam logic [15:0] LANE_BASE = 16'hB000;

endpackage

// File: rtl/bus_blkrd_cmd.sv
module bus_blkrd_cmd #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned MAX_BEATS = 8
) (
  input  logic             block_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] beats_o
);

  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_BEATS);
  localparam logic [CNT_W-1:0] ONE_C = CNT_W'(1);

  // single read, zero count and overrun all fold into legal beat numbers
  always_comb begin
    if (!block_i || cnt_i == '0) begin
      beats_o = ONE_C;
    end else if (cnt_i > MAX_C) begin
      beats_o = MAX_C;
    end else begin
      beats_o = cnt_i;
    end
  end

endmodule

// File: rtl/bus_blkrd_fsm.sv
module bus_blkrd_fsm
  import bus_blkrd_pkg::*;
#(
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned MAX_BEATS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  beats_i,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic              wait_o,
  output logic              valid_o
);

  localparam logic [CNT_W-1:0]  MAX_C   = CNT_W'(MAX_BEATS);
  localparam logic [CNT_W-1:0]  CNT_ONE = CNT_W'(1);
  localparam logic [ADDR_W-1:0] ADR_ONE = ADDR_W'(1);

  bus_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q;
  logic [CNT_W-1:0]  rem_q;
  logic              valid_q;
  logic              start;
  logic              more;

  assign start = (state_q == ST_IDLE) && mreq_i && rd_i;
  assign more  = (state_q == ST_STREAM) && (rem_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      ptr_q   <= '0;
      rem_q   <= '0;
      valid_q <= 1'b0;
    end else if (state_q != ST_IDLE && !mreq_i) begin
      state_q <= ST_IDLE;
      valid_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            ptr_q   <= start_addr_i;
            rem_q   <= beats_i;
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          ptr_q   <= ptr_q + ADR_ONE;
          rem_q   <= rem_q - CNT_ONE;
          valid_q <= 1'b1;
          state_q <= ST_STREAM;
        end
        ST_STREAM: begin
          if (more) begin
            ptr_q <= ptr_q + ADR_ONE;
            rem_q <= rem_q - CNT_ONE;
          end else begin
            valid_q <= 1'b0;
            state_q <= ST_HOLD;
          end
        end
        ST_HOLD: ;  // park until the master lets go of the request
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rd_en_o   = mreq_i && ((state_q == ST_WAIT) || more);
  assign rd_addr_o = ptr_q;
  assign wait_o    = (state_q == ST_WAIT);
  assign valid_o   = valid_q;

  AST_WAIT_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |=> !wait_o);  // R4
  AST_START_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> wait_o);  // R4
  AST_WAIT_TO_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wait_o && mreq_i) |=> valid_o);  // R3
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (more && mreq_i) |=> (ptr_q == $past(ptr_q) + ADR_ONE));  // R5
  AST_LAST_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_STREAM) && rem_q == '0) |=> !valid_o);  // R7
  AST_RELEASE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mreq_i |=> (!valid_o && !wait_o));  // R8
  AST_NO_RD_NO_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_IDLE) && mreq_i && !rd_i) |=> !wait_o);  // R9
  AST_BEATS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (beats_i != '0 && beats_i <= MAX_C));  // R6

endmodule

// File: rtl/bus_blkrd_mem.sv
module bus_blkrd_mem
  import bus_blkrd_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam int unsigned LANES = DATA_W / LANE_W;

  function automatic logic [DATA_W-1:0] seed_word(input logic [ADDR_W-1:0] a);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < LANES; k++) begin
      w[k*LANE_W +: LANE_W] = LANE_BASE + 16'(k * 256) + 16'(a);
    end
    return w;
  endfunction

  logic [DATA_W-1:0] rom_w [DEPTH];
  logic [DATA_W-1:0] rdata_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    assign rom_w[g] = seed_word(ADDR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
    end else if (rd_en_i) begin
      rdata_q <= rom_w[rd_addr_i];
    end
  end

  assign rdata_o = rdata_q;

  AST_RD_ADDR_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |-> !$isunknown(rd_addr_i));  // R5

endmodule

// File: rtl/bus_blkrd_slave.sv
module bus_blkrd_slave
  import bus_blkrd_pkg::*;
#(
  parameter int unsigned DATA_W    = 64,
  parameter int unsigned ADDR_W    = 6,
  parameter int unsigned MAX_BEATS = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mreq_i,
  input  logic              rd_i,
  input  logic              block_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic              wait_o,
  output logic              valid_o
);

  localparam int unsigned CNT_W = $clog2(MAX_BEATS + 1);

  logic [CNT_W-1:0]  beats;
  logic              rd_en;
  logic [ADDR_W-1:0] rd_addr;
  logic [DATA_W-1:0] rdata;
  logic              valid;
  logic              unused_data_hi;

  assign unused_data_hi = ^data_i[DATA_W-1:CNT_W];

  bus_blkrd_cmd #(
    .CNT_W    (CNT_W),
    .MAX_BEATS(MAX_BEATS)
  ) u_cmd (
    .block_i(block_i),
    .cnt_i  (data_i[CNT_W-1:0]),
    .beats_o(beats)
  );

  bus_blkrd_fsm #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .MAX_BEATS(MAX_BEATS)
  ) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mreq_i      (mreq_i),
    .rd_i        (rd_i),
    .start_addr_i(addr_i),
    .beats_i     (beats),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .wait_o      (wait_o),
    .valid_o     (valid)
  );

  bus_blkrd_mem #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_mem (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (rd_en),
    .rd_addr_i(rd_addr),
    .rdata_o  (rdata)
  );

  assign valid_o   = valid;
  assign data_oe_o = valid;
  assign data_o    = valid ? rdata : '0;

  AST_BUS_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> (data_o == '0));  // R7
  AST_WAIT_NOT_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wait_o && valid_o));  // R4

endmodule

// File: tb/bus_blkrd_slave_tb.sv
module bus_blkrd_slave_tb;

  localparam int CLK_P = 10;
  localparam int DW    = 64;
  localparam int AW    = 6;

  typedef struct packed {
    logic [5:0] addr;
    logic       blk;
    logic [3:0] cnt;
    logic [3:0] beats;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{6'd3,  1'b1, 4'd4,  4'd4},  // R3 four-beat burst, six cycles
    '{6'd10, 1'b0, 4'd4,  4'd1},  // R2 count ignored
    '{6'd20, 1'b1, 4'd8,  4'd8},  // R3 largest burst
    '{6'd5,  1'b1, 4'd0,  4'd1},  // R6 zero count
    '{6'd62, 1'b1, 4'd4,  4'd4},  // R5 wrap
    '{6'd40, 1'b1, 4'd1,  4'd1},  // R3 one beat
    '{6'd0,  1'b1, 4'd15, 4'd8},  // R6 clamp
    '{6'd63, 1'b1, 4'd2,  4'd2}   // R5 wrap from top
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          mreq_i = 1'b0;
  logic          rd_i = 1'b0;
  logic          block_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic          data_oe_o;
  logic          wait_o;
  logic          valid_o;

  int checks = 0;
  int fails  = 0;

  bus_blkrd_slave #(.DATA_W(DW), .ADDR_W(AW), .MAX_BEATS(8)) u_dut (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .mreq_i   (mreq_i),
    .rd_i     (rd_i),
    .block_i  (block_i),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .data_o   (data_o),
    .data_oe_o(data_oe_o),
    .wait_o   (wait_o),
    .valid_o  (valid_o)
  );

  always #(CLK_P / 2) clk_i = ~clk_i;

  function automatic logic [DW-1:0] word_of(input int a);
    logic [DW-1:0] w;
    for (int k = 0; k < DW / 16; k++) w[k*16 +: 16] = 16'hB000 + 16'(k * 256) + 16'(a % 64);
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic idle_check(input string req, input string what);
    check(!wait_o && !valid_o && !data_oe_o && data_o == '0, req, what,
          {wait_o, valid_o, data_oe_o, data_o[31:0]}, '0);
  endtask

  // start at a negedge; samples at each following negedge
  task automatic xfer(input logic [5:0] a, input logic b, input logic [3:0] c,
                      input int nb, input int hold, input string req);
    int waits = 0, vcnt = 0, last_v = 0;
    bit wait_ok = 1'b1;
    @(negedge clk_i);
    mreq_i = 1'b1; rd_i = 1'b1; block_i = b; addr_i = a;
    data_i = {60'hABCDEF012345678, c};
    for (int j = 1; j <= nb + 2; j++) begin
      @(negedge clk_i);
      block_i = 1'b0; data_i = '1; addr_i = 6'h2A;
      if (wait_o) begin
        waits++;
        if (j != 1) wait_ok = 1'b0;
      end
      if (valid_o) begin
        vcnt++;
        last_v = j;
        check(data_oe_o && data_o == word_of(int'(a) + j - 2), "R5,R10",
              $sformatf("beat %0d data", j - 2), data_o, word_of(int'(a) + j - 2));
      end
    end
    check(waits == 1 && wait_ok, "R4", "single wait in second cycle", waits, 1);
    check(vcnt == nb, req, "beat count", vcnt, nb);
    check(last_v + 1 == nb + 2, "R3", "cycles to last beat", last_v + 1, nb + 2);
    check(!valid_o && !data_oe_o && data_o == '0, "R7", "bus quiet after last beat",
          data_o, '0);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk_i);
      idle_check("R8", "no restart while request held");
    end
    mreq_i = 1'b0; rd_i = 1'b0;
    @(negedge clk_i);
    idle_check("R8", "idle after release");
  endtask

  initial begin
    #(CLK_P * 20000);
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 3);
    idle_check("R1", "outputs in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_check("R1", "outputs after reset release");

    for (int i = 0; i < NVEC; i++) begin
      string req;
      if (!VECS[i].blk) req = "R2";
      else if (VECS[i].cnt == 0 || VECS[i].cnt > 8) req = "R6";
      else req = "R3";
      xfer(VECS[i].addr, VECS[i].blk, VECS[i].cnt, int'(VECS[i].beats), 0, req);
    end

    // held request after a single read must not start a second one
    xfer(6'd33, 1'b1, 4'd1, 1, 3, "R3");

    // request without read strobe
    @(negedge clk_i);
    mreq_i = 1'b1; rd_i = 1'b0; block_i = 1'b1; data_i = 64'd4; addr_i = 6'd9;
    for (int j = 0; j < 3; j++) begin
      @(negedge clk_i);
      idle_check("R9", "no access without read strobe");
    end
    mreq_i = 1'b0; block_i = 1'b0;
    @(negedge clk_i);

    // abort a burst after two beats
    mreq_i = 1'b1; rd_i = 1'b1; block_i = 1'b1; data_i = 64'd8; addr_i = 6'd30;
    @(negedge clk_i);
    block_i = 1'b0; data_i = '0;
    @(negedge clk_i);
    check(valid_o && data_o == word_of(30), "R3", "abort run beat 0", data_o, word_of(30));
    @(negedge clk_i);
    check(valid_o && data_o == word_of(31), "R5", "abort run beat 1", data_o, word_of(31));
    mreq_i = 1'b0; rd_i = 1'b0;
    @(negedge clk_i);
    idle_check("R8", "burst stops on release");
    @(negedge clk_i);
    idle_check("R8", "stays idle after abort");
    xfer(6'd7, 1'b0, 4'd0, 1, 0, "R2");

    // reset in the middle of a burst
    @(negedge clk_i);
    mreq_i = 1'b1; rd_i = 1'b1; block_i = 1'b1; data_i = 64'd8; addr_i = 6'd12;
    @(negedge clk_i);
    block_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    idle_check("R1", "async reset mid burst");
    mreq_i = 1'b0; rd_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_check("R1", "idle after mid-burst reset");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule